// File: doc/BRIEF.md
# Sequenced Wide Unsigned Multiplier

This block multiplies two wide unsigned operands and returns the full double-width product as an upper word and a lower word. It contains only four narrow multipliers of quarter-operand width and one shared adder of operand width. The operands are split into halves, and the four half-by-half products are built one after another, three cycles each. The finished half products are then aligned and summed in three further adder passes.

A requester raises `start` for one cycle with both operands valid. The block latches the operands and holds `busy` high while it works. When the result is ready, it pulses `done` for one cycle. The result stays on `hi` and `lo` until the next completion. The default configuration is 128-bit operands with a 256-bit product, and the quarter width `W` is a parameter.

Top module: `mul128_mc`

## Requirements
- R1: At every `done` pulse, `{hi, lo}` equals the exact unsigned product of the two operands latched by the accepted `start`.
- R2: `hi` carries product bits 8W-1 down to 4W, and `lo` carries bits 4W-1 down to 0.
- R3: A `start` sampled while `busy` is low latches `opa` and `opb`, and `busy` reads high from the next cycle.
- R4: `busy` stays high for exactly 15 consecutive cycles per operation: four half products of three cycles each, plus three accumulation passes.
- R5: `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R6: A `start` sampled while `busy` is high is ignored. The result is not affected, the busy window is not lengthened, and no further operation follows.
- R7: `hi` and `lo` keep their values in every cycle except the one in which `done` rises.
- R8: After reset, `busy` and `done` are low and `hi` and `lo` are zero.
- R9: Corner operands give exact results: zero by any value, all-ones by all-ones, and single high bits.
- R10: A `start` given in the same cycle as `done` is accepted, and a new operation begins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiply; sampled only while idle |
| opa | input | 4W | Multiplicand |
| opb | input | 4W | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hi | output | 4W | Upper half of the product |
| lo | output | 4W | Lower half of the product |

## Verification
Two events can coincide in one cycle: the completion pulse of one operation and the acceptance of the next `start`. The bench drives a new request in the `done` cycle and then checks three things: the first result was still presented intact, `busy` rises on the next cycle, and the second product comes out correct after another 15-cycle window. A second collision, a request arriving while `busy` is high with different operands on the pins, is judged by the unchanged result, the unchanged window length, and the absence of any follow-on operation. The bench runs a reduced quarter width so that the expected products can be computed exactly with native 64-bit arithmetic over swept and pseudo-random operands.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_CROSS,
    ST_FORM,
    ST_ACC1,
    ST_ACC2,
    ST_ACC3
  } mst_t;

  localparam int unsigned SUB_STEPS = 3;
  localparam int unsigned SUB_COUNT = 4;
  localparam int unsigned ACC_STEPS = 3;
  localparam int unsigned BUSY_CYCLES = SUB_COUNT * SUB_STEPS + ACC_STEPS;
endpackage

// File: rtl/mul_quad.sv
module mul_quad #(
  parameter int unsigned W = 32
) (
  input  logic [2*W-1:0] x,
  input  logic [2*W-1:0] y,
  output logic [8*W-1:0] prods
);
  localparam int unsigned PW = 2 * W;

  // entry k: x half (k/2), y half (k%2); 0=ll 1=lo*hi 2=hi*lo 3=hh
  for (genvar k = 0; k < 4; k++) begin : g_mult
    logic [W-1:0] xm;
    logic [W-1:0] ym;
    if (k / 2 == 1) begin : g_xh
      assign xm = x[2*W-1:W];
    end else begin : g_xl
      assign xm = x[W-1:0];
    end
    if (k % 2 == 1) begin : g_yh
      assign ym = y[2*W-1:W];
    end else begin : g_yl
      assign ym = y[W-1:0];
    end
    assign prods[k*PW +: PW] = {{W{1'b0}}, xm} * {{W{1'b0}}, ym};
  end
endmodule

// File: rtl/mul_add.sv
module mul_add #(
  parameter int unsigned N = 128
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  assign {cout, sum} = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output mst_t       state,
  output logic [1:0] sel,
  output logic       latch_en,
  output logic       busy
);
  mst_t       state_q, state_d;
  logic [1:0] sel_q, sel_d;

  always_comb begin
    state_d  = state_q;
    sel_d    = sel_q;
    latch_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          latch_en = 1'b1;
          sel_d    = 2'd0;
          state_d  = ST_MUL;
        end
      end
      ST_MUL:   state_d = ST_CROSS;
      ST_CROSS: state_d = ST_FORM;
      ST_FORM: begin
        if (sel_q == 2'd3) begin
          state_d = ST_ACC1;
        end else begin
          sel_d   = sel_q + 2'd1;
          state_d = ST_MUL;
        end
      end
      ST_ACC1: state_d = ST_ACC2;
      ST_ACC2: state_d = ST_ACC3;
      ST_ACC3: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 2'd0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
    end
  end

  assign state = state_q;
  assign sel   = sel_q;
  assign busy  = (state_q != ST_IDLE);
endmodule

// File: rtl/mul128_mc.sv
module mul128_mc
  import mul_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [4*W-1:0] opa,
  input  logic [4*W-1:0] opb,
  output logic          busy,
  output logic          done,
  output logic [4*W-1:0] hi,
  output logic [4*W-1:0] lo
);
  localparam int unsigned HW = 2 * W;
  localparam int unsigned OW = 4 * W;

  mst_t       state;
  logic [1:0] sel;
  logic       latch_en;

  logic [OW-1:0] a_q, b_q;
  logic [HW-1:0] sx, sy;
  logic [8*W-1:0] prods;
  logic [OW-1:0] hl_q;
  logic [HW-1:0] cr0_q, cr1_q;
  logic [HW:0]   csum_q;
  logic [OW-1:0] p_q [4];
  logic [OW-1:0] t_q;
  logic          c1_q, c2_q;
  logic [HW-1:0] lou_q;
  logic [OW-1:0] hi_q, lo_q;
  logic          done_q;

  logic [OW-1:0] add_a, add_b, add_sum;
  logic          add_cin, add_cout;

  mul_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .state    (state),
    .sel      (sel),
    .latch_en (latch_en),
    .busy     (busy)
  );

  // operand halves for the current half product
  assign sx = sel[1] ? a_q[OW-1:HW] : a_q[HW-1:0];
  assign sy = sel[0] ? b_q[OW-1:HW] : b_q[HW-1:0];

  mul_quad #(.W(W)) u_quad (
    .x     (sx),
    .y     (sy),
    .prods (prods)
  );

  // shared adder operand steering
  always_comb begin
    add_a   = '0;
    add_b   = '0;
    add_cin = 1'b0;
    case (state)
      ST_CROSS: begin
        add_a = {{HW{1'b0}}, cr0_q};
        add_b = {{HW{1'b0}}, cr1_q};
      end
      ST_FORM: begin
        add_a = hl_q;
        add_b = {{(W-1){1'b0}}, csum_q, {W{1'b0}}};
      end
      ST_ACC1: begin
        add_a = p_q[1];
        add_b = p_q[2];
      end
      ST_ACC2: begin
        add_a = {{HW{1'b0}}, t_q[HW-1:0]};
        add_b = {{HW{1'b0}}, p_q[0][OW-1:HW]};
      end
      ST_ACC3: begin
        add_a   = p_q[3];
        add_b   = {{(HW-1){1'b0}}, c1_q, t_q[OW-1:HW]};
        add_cin = c2_q;
      end
      default: ;
    endcase
  end

  mul_add #(.N(OW)) u_add (
    .a    (add_a),
    .b    (add_b),
    .cin  (add_cin),
    .sum  (add_sum),
    .cout (add_cout)
  );

  logic en_mul, en_cross, en_form, en_acc1, en_acc2, en_acc3;
  assign en_mul   = (state == ST_MUL);
  assign en_cross = (state == ST_CROSS);
  assign en_form  = (state == ST_FORM);
  assign en_acc1  = (state == ST_ACC1);
  assign en_acc2  = (state == ST_ACC2);
  assign en_acc3  = (state == ST_ACC3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (latch_en) begin
      a_q <= opa;
      b_q <= opb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hl_q  <= '0;
      cr0_q <= '0;
      cr1_q <= '0;
    end else if (en_mul) begin
      hl_q  <= {prods[3*HW +: HW], prods[0 +: HW]};
      cr0_q <= prods[1*HW +: HW];
      cr1_q <= prods[2*HW +: HW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csum_q <= '0;
    end else if (en_cross) begin
      csum_q <= add_sum[HW:0];
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_part
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        p_q[k] <= '0;
      end else if (en_form && (sel == 2'(k))) begin
        p_q[k] <= add_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q  <= '0;
      c1_q <= 1'b0;
    end else if (en_acc1) begin
      t_q  <= add_sum;
      c1_q <= add_cout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lou_q <= '0;
      c2_q  <= 1'b0;
    end else if (en_acc2) begin
      lou_q <= add_sum[HW-1:0];
      c2_q  <= add_sum[HW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (en_acc3) begin
      hi_q <= add_sum;
      lo_q <= {lou_q, p_q[0][HW-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= en_acc3;
    end
  end

  assign done = done_q;
  assign hi   = hi_q;
  assign lo   = lo_q;
endmodule

// File: rtl/mul128_mc_chk.sv
module mul128_mc_chk
  import mul_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [4*W-1:0] hi,
  input logic [4*W-1:0] lo,
  input logic [4*W-1:0] a_q,
  input logic [4*W-1:0] b_q
);
  localparam int unsigned OW = 4 * W;

  logic [4:0] bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 5'd1;
    else           bcnt <= '0;
  end

  AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({hi, lo} == ({{OW{1'b0}}, a_q} * {{OW{1'b0}}, b_q}))); // R1

  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == 5'(BUSY_CYCLES))); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R5

  AST_OPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(a_q) && $stable(b_q))); // R6

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hi) && $stable(lo))); // R7
endmodule

bind mul128_mc mul128_mc_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (busy),
  .done  (done),
  .hi    (hi),
  .lo    (lo),
  .a_q   (a_q),
  .b_q   (b_q)
);

// File: tb/mul128_mc_test.sv
module mul128_mc_test;
  localparam int unsigned W  = 8;
  localparam int unsigned OW = 4 * W;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [OW-1:0] opa, opb;
  logic          busy, done;
  logic [OW-1:0] hi, lo;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  mul128_mc #(.W(W)) uut (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .opa   (opa),
    .opb   (opb),
    .busy  (busy),
    .done  (done),
    .hi    (hi),
    .lo    (lo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // Wait out a busy window whose first busy negedge is current; returns cycle count.
  task automatic wait_busy(output int n);
    n = 0;
    while (busy && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Full operation started at a negedge with busy low. R1 R2 R3 R4 R5 R7
  task automatic run_op(input logic [OW-1:0] a, input logic [OW-1:0] b, input string tag);
    logic [63:0] exp;
    int n;
    exp   = 64'(a) * 64'(b);
    start = 1'b1;
    opa   = a;
    opb   = b;
    @(negedge clk);
    start = 1'b0;
    opa   = ~a;
    opb   = ~b;
    chk(busy === 1'b1, "R3 busy after start", 64'(busy), 64'd1);
    wait_busy(n);
    chk(n == 15, "R4 busy length", 64'(n), 64'd15);
    chk(done === 1'b1, "R5 done after busy", 64'(done), 64'd1);
    chk({hi, lo} === exp, {"R1 product ", tag}, {hi, lo}, exp);
    chk(hi === exp[63:32], "R2 hi half", 64'(hi), 64'(exp[63:32]));
    @(negedge clk);
    chk(done === 1'b0, "R5 done single cycle", 64'(done), 64'd0);
    chk({hi, lo} === exp, "R7 result held", {hi, lo}, exp);
  endtask

  initial begin
    logic [63:0] exp1, exp2;
    int n;
    rst_n = 1'b0;
    start = 1'b0;
    opa   = '0;
    opb   = '0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R8 reset flags", {62'd0, busy, done}, 64'd0);
    chk({hi, lo} === 64'd0, "R8 reset result", {hi, lo}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R8 idle after release", 64'(busy), 64'd0);

    // R9 corner operands
    run_op('0, '0, "R9 zero*zero");
    run_op('1, '0, "R9 ones*zero");
    run_op('0, 32'h1234_5678, "R9 zero*x");
    run_op('1, '1, "R9 ones*ones");
    run_op(32'h8000_0000, 32'h8000_0000, "R9 msb*msb");
    run_op(32'd1, '1, "R9 one*ones");
    run_op('1, 32'h0000_0001, "R9 ones*one");

    // structured sweep over half/quarter patterns
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [OW-1:0] a, b;
        for (int q = 0; q < 4; q++) begin
          a[q*W +: W] = i[q] ? 8'hFF : 8'h00;
          b[q*W +: W] = j[q] ? 8'hFF : 8'h00;
        end
        a = a ^ {4{4'(i), 4'(j)}} & 32'h0101_0101;
        run_op(a, b, "sweep");
      end
    end

    // pseudo-random operands
    for (int k = 0; k < 300; k++) begin
      logic [OW-1:0] a;
      lfsr = next_rand(lfsr);
      a = lfsr;
      lfsr = next_rand(lfsr);
      run_op(a, lfsr, "random");
    end

    // R6: start while busy is ignored
    exp1  = 64'(32'hDEAD_BEEF) * 64'(32'h0BAD_F00D);
    start = 1'b1;
    opa   = 32'hDEAD_BEEF;
    opb   = 32'h0BAD_F00D;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1;
    opa   = '1;
    opb   = 32'h7;
    @(negedge clk);
    start = 1'b0;
    n = 5;
    while (busy && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(n == 15, "R6 window not extended", 64'(n), 64'd15);
    chk({hi, lo} === exp1, "R6 result unaffected", {hi, lo}, exp1);
    @(negedge clk);
    chk(busy === 1'b0, "R6 no follow-on op", 64'(busy), 64'd0);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && {hi, lo} === exp1, "R6 still idle, result kept", {hi, lo}, exp1);

    // R10: start in the done cycle
    exp1  = 64'(32'h0001_0001) * 64'(32'hFFFF_0000);
    exp2  = 64'(32'hCAFE_0123) * 64'(32'h89AB_CDEF);
    start = 1'b1;
    opa   = 32'h0001_0001;
    opb   = 32'hFFFF_0000;
    @(negedge clk);
    start = 1'b0;
    wait_busy(n);
    chk(done === 1'b1 && {hi, lo} === exp1, "R10 first result", {hi, lo}, exp1);
    start = 1'b1;
    opa   = 32'hCAFE_0123;
    opb   = 32'h89AB_CDEF;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R10 accepted in done cycle", 64'(busy), 64'd1);
    chk({hi, lo} === exp1, "R10 R7 old result held", {hi, lo}, exp1);
    wait_busy(n);
    chk(n == 15, "R10 second window", 64'(n), 64'd15);
    chk(done === 1'b1 && {hi, lo} === exp2, "R10 second result", {hi, lo}, exp2);
    @(negedge clk);

    finish_run();
  end
endmodule